// File: doc/BRIEF.md
# Power-Fail Flag and Output Pin Control

This block keeps a small 8-bit control/status byte. The byte holds three live bits:

- a sticky flag that records a loss of power;
- a square-wave enable;
- a static level bit.

The byte drives one output pin in one of two ways. With the enable set, the pin carries a 512 Hz square wave made from a 32.768 kHz tick. With the enable clear, the pin holds a fixed level. The bus protocol, the open-drain pad and the pull-up are outside this block.

A register write port updates the byte. A second strobe reports any write anywhere in the clock register space. The first write of any kind after power-on clears the power-loss flag. The flag then stays clear until the next power-on reset.

Top module: `pwrfail_pin_ctl`

## Requirements
- R1: In the cycle after a synchronous reset, `rdata` reads 0x81 and `pin_out` is 1.
- R2: Bits 5 down to 1 of `rdata` always read 0, even after a write of ones to those positions.
- R3: A write (`reg_wr`=1) takes `reg_wdata[7]` as the level bit and `reg_wdata[6]` as the wave enable. Both are visible on `rdata[7]` and `rdata[6]` in the next cycle. `reg_wdata[0]` is ignored. Without a write, both bits hold.
- R4: `rdata[0]` is the power-loss flag. It is 1 after reset and becomes 0 in the cycle after either `reg_wr` or `space_wr` is 1. Once 0, it stays 0 until reset.
- R5: While the wave enable is 1, `pin_out` is a square wave that toggles once every 32 `tick_in` pulses, counted from reset, whatever the level bit holds. The wave starts at 0 after reset. Between ticks the wave holds.
- R6: While the wave enable is 0, `pin_out` equals the level bit with one cycle of delay. `pin_out` is registered, so it reflects the register state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_in | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| reg_wr | input | 1 | Write strobe for this register |
| reg_wdata | input | 8 | Write data |
| space_wr | input | 1 | Strobe for a write to any clock register |
| rdata | output | 8 | Register read value |
| pin_out | output | 1 | Drive level for the output pin |

## Verification
The bench uses several write patterns:

- With the enable clear and the level bit toggled, it confirms static drive and the one-cycle delay.
- With the enable set and the level bit both 0 and 1, it shows that the wave overrides the level.
- Writes of 0xFF and 0x3E separate the masked reserved bits and the ignored flag bit from the live bits.

The flag is cleared in separate runs, once by a foreign clock-space write and once by a direct register write. A following write pattern then shows the flag cannot be set again. Ticks arrive at a steady cadence with gaps, so the model's count of 32 ticks per half period is compared against the pin on every cycle.

// File: rtl/pwrfail_pkg.sv
package pwrfail_pkg;
  localparam int REG_W     = 8;
  localparam int LVL_BIT   = 7;
  localparam int WEN_BIT   = 6;
  localparam int FLAG_BIT  = 0;
  localparam logic [REG_W-1:0] RST_VAL = 8'h81;
endpackage

// File: rtl/pwrfail_wave_div.sv
module pwrfail_wave_div #(
  parameter int HALF_TICKS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic wave
);
  localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (tick_in) begin
      if (cnt_q == LAST) begin
        cnt_q  <= '0;
        wave_q <= ~wave_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wave = wave_q;

  p_wave_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> $stable(wave_q));
endmodule

// File: rtl/pwrfail_ctrl_reg.sv
module pwrfail_ctrl_reg
  import pwrfail_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             space_wr,
  output logic             lvl,
  output logic             wen,
  output logic             flag
);
  logic lvl_q, wen_q, flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= RST_VAL[LVL_BIT];
      wen_q  <= RST_VAL[WEN_BIT];
      flag_q <= RST_VAL[FLAG_BIT];
    end else begin
      if (reg_wr) begin
        lvl_q <= reg_wdata[LVL_BIT];
        wen_q <= reg_wdata[WEN_BIT];
      end
      if (reg_wr || space_wr) flag_q <= 1'b0;
    end
  end

  assign lvl  = lvl_q;
  assign wen  = wen_q;
  assign flag = flag_q;

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    !flag_q |=> !flag_q);
  p_flag_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || space_wr) |=> !flag_q);
  p_hold_nowr_r3: assert property (@(posedge clk) disable iff (rst)
    !reg_wr |=> ($stable(lvl_q) && $stable(wen_q)));
endmodule

// File: rtl/pwrfail_pin_ctl.sv
module pwrfail_pin_ctl
  import pwrfail_pkg::*;
#(
  parameter int HALF_TICKS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_in,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             space_wr,
  output logic [REG_W-1:0] rdata,
  output logic             pin_out
);
  logic lvl, wen, flag, wave, pin_q;

  pwrfail_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .space_wr(space_wr), .lvl(lvl), .wen(wen), .flag(flag)
  );

  pwrfail_wave_div #(.HALF_TICKS(HALF_TICKS)) u_div (
    .clk(clk), .rst(rst), .tick_in(tick_in), .wave(wave)
  );

  always_comb begin
    rdata           = '0;
    rdata[LVL_BIT]  = lvl;
    rdata[WEN_BIT]  = wen;
    rdata[FLAG_BIT] = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_q <= RST_VAL[LVL_BIT];
    else     pin_q <= wen ? wave : lvl;
  end

  assign pin_out = pin_q;

  p_pin_wave_r5: assert property (@(posedge clk) disable iff (rst)
    wen |=> (pin_out == $past(wave)));
  p_pin_level_r6: assert property (@(posedge clk) disable iff (rst)
    !wen |=> (pin_out == $past(lvl)));
endmodule

// File: tb/pwrfail_pin_ctl_tb.sv
module pwrfail_pin_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       space_wr = 1'b0;
  logic [7:0] rdata;
  logic       pin_out;

  int n_chk = 0;
  int n_bad = 0;
  bit model_on = 0;

  always #10 clk = ~clk;

  pwrfail_pin_ctl dut_i (
    .clk(clk), .rst(rst), .tick_in(tick_in), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .space_wr(space_wr), .rdata(rdata), .pin_out(pin_out)
  );

  // behavioural reference: bit-level state plus tick count since reset
  bit m_lvl, m_en, m_flag, m_pin;
  int m_ticks;

  function automatic bit wave_of(int t);
    return ((t / 32) % 2) == 1;
  endfunction

  always @(posedge clk) begin
    bit nxt;
    if (rst) begin
      m_lvl = 1; m_en = 0; m_flag = 1; m_ticks = 0; m_pin = 1;
      model_on = 1;
    end else begin
      nxt = m_en ? wave_of(m_ticks) : m_lvl;
      if (tick_in) m_ticks++;
      if (reg_wr) begin m_lvl = reg_wdata[7]; m_en = reg_wdata[6]; end
      if (reg_wr || space_wr) m_flag = 0;
      m_pin = nxt;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R3", rdata, {m_lvl, m_en, 5'b0, m_flag});
      chk(m_en ? "R5" : "R6", {7'b0, pin_out}, {7'b0, m_pin});
    end
  end

  int tick_phase = 0;
  always @(negedge clk) begin
    tick_phase = (tick_phase + 1) % 3;
    tick_in <= (tick_phase == 0) && !rst;
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    idle(2); rst = 0;
    @(negedge clk);
  endtask

  initial begin
    idle(3); rst = 0;
    @(negedge clk);
    chk("R1", rdata, 8'h81);
    chk("R1", {7'b0, pin_out}, 8'h01);
    // clear flag via foreign clock-space write
    idle(5);
    @(negedge clk); space_wr = 1;
    @(negedge clk); space_wr = 0;
    chk("R4", {7'b0, rdata[0]}, 8'h00);
    // static level patterns
    wr(8'h00); chk("R3", rdata, 8'h00);
    @(negedge clk); chk("R6", {7'b0, pin_out}, 8'h00);
    wr(8'h80); @(negedge clk); chk("R6", {7'b0, pin_out}, 8'h01);
    // reserved bits and flag bit write ignored
    wr(8'hBF); chk("R2", rdata, 8'h80);
    chk("R4", {7'b0, rdata[0]}, 8'h00);
    // wave with level 1 then 0
    wr(8'hC0); idle(500);
    wr(8'h40); idle(500);
    wr(8'h80); idle(20);
    // second run: direct register write clears flag, bit0 write ignored
    do_reset();
    chk("R1", rdata, 8'h81);
    idle(4);
    wr(8'h3E);
    chk("R2", rdata, 8'h00);
    chk("R4", {7'b0, rdata[0]}, 8'h00);
    wr(8'hFF);
    chk("R4", rdata, 8'hC0);
    idle(700);
    wr(8'h81); idle(10);
    chk("R6", {7'b0, pin_out}, 8'h01);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule